// File: doc/BRIEF.md
# Smart Card Bit-Period Timing Generator

This block sets the bit timing of a smart card serial port. A locked 8-bit mode register, together with one extra code bit held in a separate one-bit control register, picks three things. The first is a power-of-four clock prescale. The second is the number of base clocks that make up one bit, and some of these counts are not powers of two. The third is parity and the flags for block transfer and GSM. A programmable 8-bit divisor N slows the prescaled clock by N+1 to form the base clock enable.

While transmit or receive is enabled, the block issues two single-cycle strobes. One marks each bit boundary. The other marks the middle of each bit, where a receiver takes its sample. The block also gives the parity bit for any data byte. The framing logic that surrounds it consumes these strobes. Configuration can only be changed while the port is idle.

Top module: `sc_bit_timer`

## Requirements
- R1: After reset the mode register reads 0x00, the extra code bit reads 1, and base_tick, bit_edge and mid_sample are 0.
- R2: A write to the mode register (wr_en) or to the extra code bit (ext_wr_en) is visible on the next clock only when tx_en and rx_en are both 0. While either enable is 1, the write is ignored and the stored value is kept.
- R3: Mode register field positions: bits [1:0] are the clock select, bits [3:2] are the low two bits of the bit-length code, bit 4 selects odd parity, bit 5 enables parity, bit 6 drives blk_mode and bit 7 drives gsm_mode.
- R4: Let c be the clock select and N the divisor, and let P = 4^c * (N+1). While the port is active, base_tick is high for one cycle at active-cycle offsets P-1, 2P-1, and so on, where offset 0 is the first active cycle.
- R5: The bit length S in base ticks comes from the 3-bit code {ext bit, mode[3:2]}: 000=93, 001=128, 010=186, 011=512, 100=32, 101=64, 110=372, 111=256.
- R6: bit_edge is high for one cycle, coinciding with base_tick, on every S-th base tick after activation.
- R7: mid_sample is high for one cycle, coinciding with base_tick, on base tick number floor(S/2) of each bit.
- R8: While tx_en and rx_en are both 0, the prescaler and bit counter stay at zero and no strobe is produced. Each new activation times from zero again.
- R9: When parity is enabled, par_bit equals the XOR of the 8 bits of par_byte, inverted if odd parity is selected. When parity is disabled, par_bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| ext_wr_en | input | 1 | Extra code bit write strobe |
| ext_wr_bit | input | 1 | Extra code bit write value |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| rate_div | input | 8 | Divisor N; base tick every N+1 prescaled clocks |
| par_byte | input | 8 | Byte whose parity is produced |
| mode_q | output | 8 | Stored mode register |
| ext_bcp_q | output | 1 | Stored extra code bit |
| blk_mode | output | 1 | Block transfer flag |
| gsm_mode | output | 1 | GSM flag |
| base_tick | output | 1 | Base clock enable strobe |
| bit_edge | output | 1 | Bit boundary strobe |
| mid_sample | output | 1 | Mid-bit sample strobe |
| par_bit | output | 1 | Parity bit of par_byte |

## Verification
The assertions check on every cycle that the strobes stay silent while the port is idle, and that neither bit strobe appears without a base tick. They also check that the boundary and sample strobes never coincide or repeat back to back, that the configuration holds steady while the port is active, and that parity is zero when disabled. The exact spacing of the strobes for each of the eight bit lengths can only be shown by the bench's sweeps, which count cycles from activation. The same applies to the prescale and divisor products, to the restart from zero after an idle gap, and to the parity value of every byte.

// File: rtl/sc_timer_pkg.sv
package sc_timer_pkg;

    localparam int MODE_W = 8;
    localparam int LEN_W  = 10;   // holds the largest bit length, 512
    localparam int CNT_W  = 9;    // counts 0 .. 511

    typedef struct packed {
        logic       gsm;
        logic       blk;
        logic       par_en;
        logic       par_odd;
        logic [1:0] len_lo;
        logic [1:0] clk_sel;
    } mode_t;

    // Number of base ticks per bit for the 3-bit length code
    function automatic logic [LEN_W-1:0] bit_len(input logic [2:0] code);
        logic [LEN_W-1:0] s;
        case (code)
            3'b000:  s = 10'd93;
            3'b001:  s = 10'd128;
            3'b010:  s = 10'd186;
            3'b011:  s = 10'd512;
            3'b100:  s = 10'd32;
            3'b101:  s = 10'd64;
            3'b110:  s = 10'd372;
            default: s = 10'd256;
        endcase
        return s;
    endfunction

    function automatic logic byte_parity(input logic [7:0] b, input logic en, input logic odd);
        return en & ((^b) ^ odd);
    endfunction

endpackage

// File: rtl/sc_mode_reg.sv
module sc_mode_reg
    import sc_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              unlocked,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_data,
    input  logic              ext_wr_en,
    input  logic              ext_wr_bit,
    output mode_t             mode_q,
    output logic              ext_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ext_q  <= 1'b1;
        end else if (unlocked) begin
            if (wr_en)     mode_q <= mode_t'(wr_data);
            if (ext_wr_en) ext_q  <= ext_wr_bit;
        end
    end

endmodule

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
    parameter int SEL_STEP = 2,   // log2 of the ratio between adjacent selects
    parameter int SEL_NUM  = 4,   // number of prescale selections
    parameter int DIV_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       run,
    input  logic [$clog2(SEL_NUM)-1:0] clk_sel,
    input  logic [DIV_W-1:0]           divisor,
    output logic                       base_tick
);

    localparam int PRE_W = SEL_STEP * (SEL_NUM - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_lim;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_tick;

    // low SEL_STEP*clk_sel bits set gives a limit of 4^c - 1
    always_comb begin
        pre_lim = '0;
        for (int i = 0; i < PRE_W; i++)
            pre_lim[i] = (i < SEL_STEP * int'(clk_sel));
    end

    assign pre_tick  = run && (pre_cnt == pre_lim);
    assign base_tick = pre_tick && (div_cnt == divisor);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
            if (base_tick)     div_cnt <= '0;
            else if (pre_tick) div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sc_bit_counter.sv
module sc_bit_counter
    import sc_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] len,
    output logic             bit_edge,
    output logic             mid_sample
);

    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] last_w;
    logic [LEN_W-1:0] half_w;
    logic             at_last;

    assign last_w  = len - LEN_W'(1);
    assign half_w  = (len >> 1) - LEN_W'(1);
    assign at_last = (cnt == last_w[CNT_W-1:0]);

    assign bit_edge   = tick && at_last;
    assign mid_sample = tick && (cnt == half_w[CNT_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || !run)  cnt <= '0;
        else if (tick)    cnt <= at_last ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/sc_bit_timer.sv
module sc_bit_timer
    import sc_timer_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             ext_wr_en,
    input  logic             ext_wr_bit,
    input  logic             tx_en,
    input  logic             rx_en,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [7:0]       par_byte,
    output logic [7:0]       mode_q,
    output logic             ext_bcp_q,
    output logic             blk_mode,
    output logic             gsm_mode,
    output logic             base_tick,
    output logic             bit_edge,
    output logic             mid_sample,
    output logic             par_bit
);

    mode_t            mode;
    logic             active;
    logic [LEN_W-1:0] len;

    assign active = tx_en | rx_en;

    sc_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .unlocked   (!active),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ext_wr_en  (ext_wr_en),
        .ext_wr_bit (ext_wr_bit),
        .mode_q     (mode),
        .ext_q      (ext_bcp_q)
    );

    assign len = bit_len({ext_bcp_q, mode.len_lo});

    sc_prescaler #(.SEL_STEP(2), .SEL_NUM(4), .DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (active),
        .clk_sel   (mode.clk_sel),
        .divisor   (rate_div),
        .base_tick (base_tick)
    );

    sc_bit_counter u_bits (
        .clk        (clk),
        .rst        (rst),
        .run        (active),
        .tick       (base_tick),
        .len        (len),
        .bit_edge   (bit_edge),
        .mid_sample (mid_sample)
    );

    assign mode_q   = mode;
    assign blk_mode = mode.blk;
    assign gsm_mode = mode.gsm;
    assign par_bit  = byte_parity(par_byte, mode.par_en, mode.par_odd);

endmodule

// File: rtl/sc_bit_timer_chk.sv
module sc_bit_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_en,
    input logic       rx_en,
    input logic [7:0] mode_q,
    input logic       ext_bcp_q,
    input logic       base_tick,
    input logic       bit_edge,
    input logic       mid_sample,
    input logic       par_bit
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mode_q == 8'h00) && ext_bcp_q);

    // R2
    write_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en || rx_en) |=> ($stable(mode_q) && $stable(ext_bcp_q)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(tx_en || rx_en) |-> !(base_tick || bit_edge || mid_sample));

    // R6
    edge_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        bit_edge |-> base_tick);

    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_edge |=> !bit_edge);

    // R7
    mid_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        mid_sample |-> (base_tick && !bit_edge));

    // R9
    parity_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_q[5] |-> !par_bit);

endmodule

bind sc_bit_timer sc_bit_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .mode_q     (mode_q),
    .ext_bcp_q  (ext_bcp_q),
    .base_tick  (base_tick),
    .bit_edge   (bit_edge),
    .mid_sample (mid_sample),
    .par_bit    (par_bit)
);

// File: tb/sc_bit_timer_test.sv
module sc_bit_timer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_wr_en = 1'b0;
    logic       ext_wr_bit = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic [7:0] rate_div = '0;
    logic [7:0] par_byte = '0;
    logic [7:0] mode_q;
    logic       ext_bcp_q, blk_mode, gsm_mode;
    logic       base_tick, bit_edge, mid_sample, par_bit;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    sc_bit_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ext_wr_en(ext_wr_en), .ext_wr_bit(ext_wr_bit),
        .tx_en(tx_en), .rx_en(rx_en), .rate_div(rate_div), .par_byte(par_byte),
        .mode_q(mode_q), .ext_bcp_q(ext_bcp_q), .blk_mode(blk_mode), .gsm_mode(gsm_mode),
        .base_tick(base_tick), .bit_edge(bit_edge), .mid_sample(mid_sample), .par_bit(par_bit)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input int code);
        case (code)
            0: return 93;   1: return 128;  2: return 186;  3: return 512;
            4: return 32;   5: return 64;   6: return 372;  default: return 256;
        endcase
    endfunction

    // write both registers while idle; visible at the following negedge
    task automatic cfg(input logic [7:0] m, input logic e);
        wr_en = 1'b1; wr_data = m; ext_wr_en = 1'b1; ext_wr_bit = e;
        @(negedge clk);
        wr_en = 1'b0; ext_wr_en = 1'b0;
    endtask

    // R4 R5 R6 R7: count active cycles and compare every strobe
    task automatic run(input int cks, input int code, input int n, input int cycles, input bit use_rx);
        int p, s, ph;
        cfg({4'b0000, code[1:0], cks[1:0]}, code[2]);
        p = (4 ** cks) * (n + 1);
        s = len_of(code);
        rate_div = n[7:0];
        if (use_rx) rx_en = 1'b1; else tx_en = 1'b1;
        for (int t = 0; t < cycles; t++) begin
            #1;
            ph = (t + 1) % (s * p);
            chk("R4 base_tick", int'(base_tick), int'(((t + 1) % p) == 0));
            chk("R6 bit_edge", int'(bit_edge), int'(ph == 0));
            chk("R7 mid_sample", int'(mid_sample), int'(ph == (s / 2) * p));
            @(negedge clk);
        end
        tx_en = 1'b0; rx_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 mode_q", int'(mode_q), 0);
        chk("R1 ext_bcp_q", int'(ext_bcp_q), 1);
        chk("R1 strobes", int'({base_tick, bit_edge, mid_sample}), 0);
        @(negedge clk);

        // R2 writes while active are ignored
        rx_en = 1'b1; wr_en = 1'b1; wr_data = 8'hA5; ext_wr_en = 1'b1; ext_wr_bit = 1'b0;
        @(negedge clk); #1;
        chk("R2 locked mode (rx)", int'(mode_q), 0);
        chk("R2 locked ext (rx)", int'(ext_bcp_q), 1);
        @(negedge clk);
        rx_en = 1'b0; tx_en = 1'b1;
        @(negedge clk); #1;
        chk("R2 locked mode (tx)", int'(mode_q), 0);
        chk("R2 locked ext (tx)", int'(ext_bcp_q), 1);
        @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk); #1;
        chk("R2 accepted mode", int'(mode_q), 8'hA5);
        chk("R2 accepted ext", int'(ext_bcp_q), 0);
        @(negedge clk);
        wr_en = 1'b0; ext_wr_en = 1'b0;

        // R3 flag positions
        cfg(8'h80, 1'b1); #1;
        chk("R3 gsm_mode", int'(gsm_mode), 1);
        chk("R3 blk_mode", int'(blk_mode), 0);
        @(negedge clk);
        cfg(8'h40, 1'b1); #1;
        chk("R3 blk_mode", int'(blk_mode), 1);
        chk("R3 gsm_mode", int'(gsm_mode), 0);
        @(negedge clk);

        // R8 idle: no strobes
        for (int i = 0; i < 20; i++) begin
            #1; chk("R8 idle strobes", int'({base_tick, bit_edge, mid_sample}), 0);
            @(negedge clk);
        end

        // R9 exhaustive parity with R3 bits 5 and 4
        for (int m = 0; m < 4; m++) begin
            cfg({2'b00, m[1:0], 4'b0000}, 1'b1);
            for (int b = 0; b < 256; b++) begin
                par_byte = b[7:0]; #1;
                chk("R9 par_bit", int'(par_bit), m[1] ? int'((^b[7:0]) ^ m[0]) : 0);
                @(negedge clk);
            end
        end

        // R5 every length code at unit prescale, two bits each
        for (int c = 0; c < 8; c++) run(0, c, 0, 2 * len_of(c), c[0]);
        // R4 prescale and divisor products
        run(1, 4, 0, 2 * 32 * 4, 1'b0);
        run(1, 4, 3, 2 * 32 * 16, 1'b1);
        run(2, 4, 1, 2 * 32 * 32, 1'b0);
        run(3, 4, 0, 2 * 32 * 64, 1'b1);
        run(0, 4, 5, 2 * 32 * 6, 1'b0);
        run(1, 0, 1, 2 * 93 * 8, 1'b1);
        // R8 partial bit then restart from zero
        run(0, 5, 2, 50, 1'b0);
        run(0, 5, 2, 2 * 64 * 3, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule